// File: doc/BRIEF.md
# Priority Region Permission Checker

The block decides whether an unprivileged access to a memory buffer may proceed. A table of protection regions sits in local registers. Each region has a base word and an attribute word, and both are loaded through a simple register-write port. A request names a buffer start address, a byte length and a read/write flag. The block then walks the table from the highest region index down to index zero, one region per clock cycle.

The first region on this walk that is enabled and holds the whole buffer settles the outcome. Its permission field sets grant or deny, and the walk stops there, even when the answer is deny. If no enabled region holds the whole buffer, the answer is deny. The answer appears as a single-cycle done pulse, and the grant flag is valid only during that pulse.

Top module: `region_perm_chk`

## Requirements
- R1: After reset, busy_o, done_o and granted_o are all 0.
- R2: A cycle with cfg_we_i high writes cfg_wdata_i into region cfg_idx_i. With cfg_sel_i=0 the write goes to the base word, and with cfg_sel_i=1 it goes to the attribute word. The region base is the base word with bits 4:0 forced to zero, so those five bits have no effect.
- R3: Attribute bit 0 is the enable bit. The walk skips any region whose enable bit is 0.
- R4: The size code in attribute bits 5:1 makes a region span 2^(code+1) bytes starting at its base. A region holds the buffer only when addr_i >= base and addr_i+size_i-1 <= base+2^(code+1)-1.
- R5: The highest-index enabled region that holds the buffer decides the result, even when its decision is deny. If that region has index i, done_o is high in the (8-i)th cycle after the start edge.
- R6: A write is granted only when attribute bits 26:24 equal 3'b011.
- R7: A read is granted when attribute bit 25 is 1.
- R8: When no enabled region holds the buffer, done_o pulses with granted_o=0 in the 8th cycle after the start edge.
- R9: A request with size_i=0 is denied. A buffer whose last byte lies past address 0xFFFFFFFF matches no region.
- R10: busy_o rises in the cycle after an accepted start and falls with done_o. A start_i pulse seen while busy_o is high is ignored.
- R11: done_o is high for exactly one cycle per accepted request. granted_o is 0 whenever done_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Region register write enable |
| cfg_idx_i | input | 3 | Region index for the write |
| cfg_sel_i | input | 1 | 0 selects the base word, 1 selects the attribute word |
| cfg_wdata_i | input | 32 | Write data |
| start_i | input | 1 | Request pulse |
| addr_i | input | 32 | Buffer start address |
| size_i | input | 32 | Buffer length in bytes |
| write_i | input | 1 | 1 for a write access, 0 for a read access |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | One-cycle result strobe |
| granted_o | output | 1 | Access allowed, valid while done_o is high |

## Verification
The assertions assume that start_i is a one-cycle pulse and that the region table is not rewritten while a walk is in progress. The stimulus keeps to both assumptions: it issues configuration writes only between requests, and it drops start_i on the next falling edge. The one exception is a deliberate start pulse sent while busy_o is high, which checks that such a pulse is ignored. Random tables place regions near each other with small size codes, so overlaps, holds, partial overlaps and zero lengths all occur often. Directed cases cover the exact-fit boundary, address wrap, base low bits and the priority of a deny.

// File: rtl/region_perm_pkg.sv
package region_perm_pkg;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned EN_BIT     = 0;
  localparam int unsigned SZ_LSB     = 1;
  localparam int unsigned SZ_W       = 5;
  localparam int unsigned AP_LSB     = 24;
  localparam int unsigned AP_W       = 3;
  localparam int unsigned BASE_ALIGN = 5;
  localparam logic [AP_W-1:0] AP_FULL_RW = 3'b011;
  localparam int unsigned AP_USER_RD_BIT = 1;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W:0]   last;   // 33-bit inclusive end address
    logic              zero;
    logic              wr;
  } req_t;
endpackage

// File: rtl/region_table.sv
module region_table
  import region_perm_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  localparam int unsigned IDX_W = $clog2(NUM_REGIONS)
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  we_i,
  input  logic [IDX_W-1:0]                      idx_i,
  input  logic                                  sel_i,
  input  logic [ADDR_W-1:0]                     wdata_i,
  input  logic [IDX_W-1:0]                      rd_idx_i,
  output logic [ADDR_W-1:0]                     rd_base_o,
  output logic [ADDR_W-1:0]                     rd_attr_o
);
  logic [NUM_REGIONS-1:0][ADDR_W-1:0] base_q;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0] attr_q;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[g] <= '0;
        attr_q[g] <= '0;
      end else if (we_i && (idx_i == IDX_W'(g))) begin
        if (sel_i) attr_q[g] <= wdata_i;
        else       base_q[g] <= {wdata_i[ADDR_W-1:BASE_ALIGN], {BASE_ALIGN{1'b0}}};
      end
    end
  end

  assign rd_base_o = base_q[rd_idx_i];
  assign rd_attr_o = attr_q[rd_idx_i];
endmodule

// File: rtl/region_match.sv
module region_match
  import region_perm_pkg::*;
(
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] attr_i,
  input  req_t              req_i,
  output logic              hit_o,
  output logic              allow_o
);
  logic [SZ_W:0]      shift;
  logic [ADDR_W:0]    span;
  logic [ADDR_W:0]    r_last;
  logic [AP_W-1:0]    ap;
  logic               en;

  always_comb begin
    en     = attr_i[EN_BIT];
    shift  = {1'b0, attr_i[SZ_LSB +: SZ_W]} + 1'b1;
    span   = (ADDR_W+1)'(1) << shift;
    r_last = {1'b0, base_i} + span - 1'b1;
    ap     = attr_i[AP_LSB +: AP_W];
    hit_o  = en && !req_i.zero && !req_i.last[ADDR_W] &&
             (req_i.addr >= base_i) && (req_i.last <= r_last);
    allow_o = req_i.wr ? (ap == AP_FULL_RW) : ap[AP_USER_RD_BIT];
  end
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import region_perm_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  localparam int unsigned IDX_W = $clog2(NUM_REGIONS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] size_i,
  input  logic              write_i,
  input  logic              hit_i,
  input  logic              allow_i,
  output req_t              req_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              granted_o
);
  scan_state_e      state_q;
  req_t             req_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q, grant_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      req_q   <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
      grant_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      grant_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q    <= ST_SCAN;
          idx_q      <= IDX_W'(NUM_REGIONS-1);
          req_q.addr <= addr_i;
          req_q.last <= {1'b0, addr_i} + {1'b0, size_i} - 1'b1;
          req_q.zero <= (size_i == '0);
          req_q.wr   <= write_i;
        end
        ST_SCAN: begin
          if (hit_i) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            grant_q <= allow_i;
          end else if (idx_q == '0) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            idx_q <= idx_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_o     = req_q;
  assign idx_o     = idx_q;
  assign busy_o    = (state_q == ST_SCAN);
  assign done_o    = done_q;
  assign granted_o = grant_q;
endmodule

// File: rtl/region_perm_chk.sv
module region_perm_chk
  import region_perm_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  localparam int unsigned IDX_W = $clog2(NUM_REGIONS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic              cfg_sel_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              start_i,
  input  logic [31:0]       addr_i,
  input  logic [31:0]       size_i,
  input  logic              write_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              granted_o
);
  logic [IDX_W-1:0]  scan_idx;
  logic [ADDR_W-1:0] cur_base, cur_attr;
  req_t              req;
  logic              hit, allow;

  region_table #(.NUM_REGIONS(NUM_REGIONS)) u_table (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .idx_i(cfg_idx_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .rd_idx_i(scan_idx), .rd_base_o(cur_base), .rd_attr_o(cur_attr)
  );

  region_match u_match (
    .base_i(cur_base), .attr_i(cur_attr), .req_i(req), .hit_o(hit), .allow_o(allow)
  );

  scan_ctrl #(.NUM_REGIONS(NUM_REGIONS)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .addr_i, .size_i, .write_i,
    .hit_i(hit), .allow_i(allow), .req_o(req), .idx_o(scan_idx),
    .busy_o, .done_o, .granted_o
  );
endmodule

// File: rtl/region_perm_chk_sva.sv
module region_perm_chk_sva #(
  parameter int unsigned NUM_REGIONS = 8
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [31:0] size_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        granted_o
);
  logic        zero_q;
  logic [7:0]  busy_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zero_q     <= 1'b0;
      busy_cnt_q <= '0;
    end else begin
      if (start_i && !busy_o) zero_q <= (size_i == '0);
      busy_cnt_q <= busy_o ? busy_cnt_q + 1'b1 : '0;
    end
  end

  AST_GRANT_ONLY_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    granted_o |-> done_o); // R11
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_BUSY_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R10
  AST_BUSY_DROPS_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R10
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R10
  AST_ZERO_LEN_DENY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && zero_q) |-> !granted_o); // R9
  AST_SCAN_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cnt_q <= 8'(NUM_REGIONS)); // R8
endmodule

bind region_perm_chk region_perm_chk_sva #(.NUM_REGIONS(NUM_REGIONS)) u_sva (
  .clk_i, .rst_ni, .start_i, .size_i, .busy_o, .done_o, .granted_o
);

// File: tb/region_perm_chk_tb_top.sv
module region_perm_chk_tb_top;
  localparam int NR = 8;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_we_i = 1'b0, cfg_sel_i = 1'b0;
  logic [2:0] cfg_idx_i = '0;
  logic [31:0] cfg_wdata_i = '0, addr_i = '0, size_i = '0;
  logic start_i = 1'b0, write_i = 1'b0;
  logic busy_o, done_o, granted_o;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_base [NR];
  logic [31:0] m_attr [NR];

  always #10 clk_i = ~clk_i;

  region_perm_chk dut_i (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input int idx, input bit sel, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_idx_i = 3'(idx); cfg_sel_i = sel; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    if (sel) m_attr[idx] = d; else m_base[idx] = d & 32'hFFFF_FFE0;
  endtask

  function automatic logic [31:0] mk_attr(input bit en, input int code, input logic [2:0] ap);
    return {5'b0, ap, 18'b0, 5'(code), en};
  endfunction

  // expected: returns granted, sets cycle count from start edge to done (+1 for sampling)
  function automatic bit model(input logic [31:0] a, input logic [31:0] s, input bit wr, output int cyc);
    longint unsigned last, rb, rl;
    logic [2:0] ap;
    cyc = NR + 1;
    if (s == 0) return 1'b0;
    last = longint'(a) + longint'(s) - 1;
    if (last > 64'hFFFF_FFFF) return 1'b0;
    for (int i = NR - 1; i >= 0; i--) begin
      if (!m_attr[i][0]) continue;
      rb = longint'(m_base[i]);
      rl = rb + (64'd1 << (m_attr[i][5:1] + 1)) - 1;
      if (longint'(a) >= rb && last <= rl) begin
        cyc = NR - i + 1;
        ap = m_attr[i][26:24];
        return wr ? (ap == 3'b011) : ap[1];
      end
    end
    return 1'b0;
  endfunction

  task automatic run(input logic [31:0] a, input logic [31:0] s, input bit wr, input string req,
                     input bit poke_busy = 1'b0);
    int cyc, ecyc;
    bit eg, g;
    eg = model(a, s, wr, ecyc);
    @(negedge clk_i);
    start_i = 1'b1; addr_i = a; size_i = s; write_i = wr;
    @(negedge clk_i);
    start_i = 1'b0;
    cyc = 1;
    if (poke_busy) begin
      check(busy_o == 1'b1, "R10 busy", busy_o, 1);
      start_i = 1'b1; addr_i = ~a; size_i = 32'd4; write_i = ~wr;
      @(negedge clk_i);
      start_i = 1'b0;
      cyc++;
    end
    while (!done_o && cyc < 40) begin
      @(negedge clk_i);
      cyc++;
    end
    g = granted_o;
    check(g == eg, {req, " granted"}, g, eg);
    check(cyc == ecyc, {req, " latency"}, cyc, ecyc);
    @(negedge clk_i);
    check(!done_o && !granted_o && !busy_o, "R11 pulse", {done_o, granted_o, busy_o}, 0);
    if (poke_busy) begin
      repeat (12) begin
        @(negedge clk_i);
        if (done_o) check(1'b0, "R10 ignored start", 1, 0);
      end
      check(!busy_o, "R10 idle after ignore", busy_o, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    check(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NR; i++) begin m_base[i] = '0; m_attr[i] = '0; end
    repeat (3) @(negedge clk_i);
    check(!busy_o && !done_o && !granted_o, "R1 reset", {busy_o, done_o, granted_o}, 0);
    rst_ni = 1'b1;

    // R8 / R3: empty table denies after full walk
    run(32'h1000, 32'd16, 1'b0, "R8 empty");
    // R6 / R7: region 2 full rw, 256 bytes (code 7)
    cfg(2, 0, 32'h0000_1000);
    cfg(2, 1, mk_attr(1, 7, 3'b011));
    run(32'h1010, 32'd32, 1'b0, "R7 read rw");
    run(32'h1010, 32'd32, 1'b1, "R6 write rw");
    // R5: higher read-only region decides, deny on write stops walk
    cfg(5, 0, 32'h0000_1000);
    cfg(5, 1, mk_attr(1, 7, 3'b010));
    run(32'h1010, 32'd32, 1'b0, "R7 read ro");
    run(32'h1010, 32'd32, 1'b1, "R5 deny stops");
    cfg(5, 1, mk_attr(1, 7, 3'b001));
    run(32'h1010, 32'd8, 1'b0, "R7 read no user");
    cfg(5, 1, mk_attr(1, 7, 3'b111));
    run(32'h1010, 32'd8, 1'b1, "R6 write 111");
    // R3: disabled region skipped
    cfg(5, 1, mk_attr(0, 7, 3'b000));
    run(32'h1010, 32'd8, 1'b1, "R3 skip disabled");
    // R4: exact fit and one byte past
    run(32'h1000, 32'd256, 1'b0, "R4 exact fit");
    run(32'h1000, 32'd257, 1'b0, "R4 past end");
    run(32'h0FFF, 32'd2, 1'b0, "R4 below base");
    // R9: zero length and wrap
    run(32'h1010, 32'd0, 1'b0, "R9 zero length");
    cfg(7, 0, 32'hFFFF_FF00);
    cfg(7, 1, mk_attr(1, 31, 3'b011));
    run(32'hFFFF_FFF0, 32'h20, 1'b0, "R9 wrap");
    run(32'hFFFF_FFF0, 32'h10, 1'b0, "R9 top fit");
    // R2: base low bits ignored; region 6 of 32 bytes (code 4)
    cfg(6, 0, 32'h0000_803F);
    cfg(6, 1, mk_attr(1, 4, 3'b011));
    run(32'h0000_8020, 32'd32, 1'b1, "R2 base mask");
    // R10: start while busy ignored
    run(32'h1010, 32'd8, 1'b0, "R10 busy start", 1'b1);

    // random tables and requests
    for (int t = 0; t < 40; t++) begin
      for (int i = 0; i < NR; i++) begin
        cfg(i, 0, 32'h2000_0000 + ($urandom & 32'h0000_0FE0));
        cfg(i, 1, mk_attr(($urandom % 4) != 0, 4 + $urandom % 6, 3'($urandom)));
      end
      for (int k = 0; k < 8; k++) begin
        int r;
        logic [31:0] a;
        r = $urandom % NR;
        a = m_base[r] + ($urandom % (32'd1 << (m_attr[r][5:1] + 1)));
        run(a, $urandom % 72, 1'($urandom), "R5 random");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule